// File: doc/BRIEF.md
# Paired Register Stack Push/Pop Unit

This unit carries out stack save and restore operations for 64-bit general-purpose registers against a stack that grows toward lower addresses. A decoded request names one of four operations: a single push, a single pop, a paired push or a paired pop. It also carries two register identifiers, the addressing-mode field, the new-destination flag and the current stack pointer. The unit holds the 32-entry register file. It reads the file for pushes, writes popped values back into it, and drives a single 64-bit memory port. When an operation completes it reports the new stack pointer.

Paired operations move two registers with one request, so they have to be checked before they are allowed to run. The unit rejects a paired request as an undefined instruction if it uses a memory-operand mode, if the second identifier is not enabled, if either identifier names the stack pointer, or if it is a pop that names the same register twice. If none of these apply but the stack is not 16-byte aligned, it raises a general-protection fault instead. A rejected request causes no memory access, no register write and no stack pointer update. A paired push issues both of its stores only after all checks have passed, and it issues them in two consecutive cycles.

Top module: `pair_stack_unit`

## Requirements
- R1: Operation code 2'b00 (single push) stores register B at SP-8, asserts `done` two cycles after acceptance, and reports SP-8 on `sp_out`.
- R2: Operation code 2'b01 (single pop) reads SP, writes the returned word into register B, and reports SP+8 on `sp_out` together with `done`.
- R3: Operation code 2'b10 (paired push) stores B at SP-8 in the first cycle after acceptance and V at SP-16 in the very next cycle, then reports SP-16 with `done`.
- R4: Operation code 2'b11 (paired pop) loads B from SP and V from SP+8 in two consecutive read cycles, then reports SP+16 with `done`.
- R5: A paired request whose mode field is not 2'b11 raises `fault_ud`.
- R6: A paired request with the new-destination flag low raises `fault_ud`.
- R7: A paired request where B or V equals identifier 4 (the stack pointer) raises `fault_ud`.
- R8: A paired pop with B equal to V raises `fault_ud`. A paired push with B equal to V is legal.
- R9: A paired request whose SP has any of bits [3:0] set raises `fault_gp`, but only when no undefined-instruction condition holds. Otherwise `fault_ud` takes priority.
- R10: A fault pulses for one cycle, one cycle after acceptance. It makes no memory access, no register write and no `done`, and the unit is free again in the next cycle.
- R11: Single operations ignore the mode field, the flag, V and the alignment of SP, and they may use identifier 4.
- R12: Out of reset, `busy`, `mem_req`, `done`, `fault_ud` and `fault_gp` are all low.
- R13: Memory read data is taken one cycle after the read request. At most one of `done`, `fault_ud` and `fault_gp` is high in any cycle.
- R14: The load port writes a register. A unit writeback in the same cycle wins over the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 2 | 00 push, 01 pop, 10 paired push, 11 paired pop |
| req_breg | input | 5 | First register identifier |
| req_vreg | input | 5 | Second register identifier (paired only) |
| req_mod | input | 2 | Addressing-mode field; paired needs 2'b11 |
| req_nd | input | 1 | New-destination flag; paired needs 1 |
| req_sp | input | 64 | Current stack pointer |
| ld_we | input | 1 | Register load strobe |
| ld_addr | input | 5 | Register load index |
| ld_data | input | 64 | Register load value |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | 64 | Byte address of the access |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid one cycle after the read request |
| done | output | 1 | Completion pulse |
| sp_out | output | 64 | Updated stack pointer, valid with `done` |
| fault_ud | output | 1 | Undefined-instruction fault pulse |
| fault_gp | output | 1 | General-protection fault pulse |

## Verification
The hardest case to observe is that a rejected request leaves the register file alone, because the file has no read port. The bench handles this in two steps. First it issues a faulting paired pop that targets two registers loaded with known values. It then pushes those same registers as a legal pair and compares the stored words against the original values. Fault priority is exercised with requests that are both misaligned and illegal. Pop results are checked by pushing the popped registers back out.

// File: rtl/pstk_pkg.sv
package pstk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH  = 2'b00,
    OP_POP   = 2'b01,
    OP_PUSH2 = 2'b10,
    OP_POP2  = 2'b11
  } pstk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ACC1 = 2'b01,
    ST_ACC2 = 2'b10,
    ST_FIN  = 2'b11
  } pstk_state_e;

  typedef enum logic [1:0] {
    VD_OK = 2'b00,
    VD_UD = 2'b01,
    VD_GP = 2'b10
  } pstk_verdict_e;

endpackage

// File: rtl/pstk_regfile.sv
module pstk_regfile #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [ID_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] rd_val
);
  localparam int NREG = 1 << ID_W;

  logic [DATA_W-1:0] cells [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == ID_W'(g))) begin
        cells[g] <= wr_val;
      end
    end
  end

  assign rd_val = cells[rd_idx];

endmodule

// File: rtl/pstk_legal.sv
module pstk_legal
  import pstk_pkg::*;
#(
  parameter int ID_W      = 5,
  parameter int SP_ID     = 4,
  parameter int ALIGN_LSB = 4
) (
  input  logic [1:0]           op,
  input  logic [ID_W-1:0]      b_id,
  input  logic [ID_W-1:0]      v_id,
  input  logic [1:0]           mode,
  input  logic                 nd,
  input  logic [ALIGN_LSB-1:0] sp_low,
  output pstk_verdict_e        verdict
);
  logic paired;
  logic is_pop;
  logic bad_form;
  logic bad_id;
  logic dup_pop;
  logic misaligned;

  always_comb begin
    paired     = op[1];
    is_pop     = op[0];
    bad_form   = (mode != 2'b11) || !nd;
    bad_id     = (b_id == ID_W'(SP_ID)) || (v_id == ID_W'(SP_ID));
    dup_pop    = is_pop && (b_id == v_id);
    misaligned = |sp_low;
    if (!paired) begin
      verdict = VD_OK;
    end else if (bad_form || bad_id || dup_pop) begin
      verdict = VD_UD;
    end else if (misaligned) begin
      verdict = VD_GP;
    end else begin
      verdict = VD_OK;
    end
  end

endmodule

// File: rtl/pstk_seq.sv
module pstk_seq
  import pstk_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ID_W       = 5,
  parameter int SLOT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  pstk_verdict_e     verdict,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_b,
  input  logic [ID_W-1:0]   req_v,
  input  logic [DATA_W-1:0] req_sp,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ID_W-1:0]   rf_ridx,
  output logic              wb_en,
  output logic [ID_W-1:0]   wb_idx,
  output logic [DATA_W-1:0] wb_val,
  output logic              done,
  output logic [DATA_W-1:0] sp_out,
  output logic              fault_ud,
  output logic              fault_gp
);
  localparam logic [DATA_W-1:0] STEP1 = DATA_W'(SLOT_BYTES);
  localparam logic [DATA_W-1:0] STEP2 = DATA_W'(2 * SLOT_BYTES);

  pstk_state_e       st_q, st_d;
  pstk_op_e          op_q;
  logic [ID_W-1:0]   b_q, v_q;
  logic [DATA_W-1:0] sp_q;
  logic              ud_q, ud_d, gp_q, gp_d;
  logic              start;

  // next-state
  always_comb begin
    start = accept && (verdict == VD_OK);
    ud_d  = accept && (verdict == VD_UD);
    gp_d  = accept && (verdict == VD_GP);
    st_d  = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_ACC1;
      ST_ACC1: st_d = op_q[1] ? ST_ACC2 : ST_FIN;
      ST_ACC2: st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ud_q <= 1'b0;
      gp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ud_q <= ud_d;
      gp_q <= gp_d;
    end
  end

  // request latch, clock-enabled on a legal start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_PUSH;
      b_q  <= '0;
      v_q  <= '0;
      sp_q <= '0;
    end else if (start) begin
      op_q <= pstk_op_e'(req_op);
      b_q  <= req_b;
      v_q  <= req_v;
      sp_q <= req_sp;
    end
  end

  // access and result outputs
  always_comb begin
    busy     = (st_q != ST_IDLE);
    mem_req  = (st_q == ST_ACC1) || (st_q == ST_ACC2);
    mem_we   = mem_req && !op_q[0];
    rf_ridx  = (st_q == ST_ACC2) ? v_q : b_q;
    if (op_q[0]) begin
      mem_addr = (st_q == ST_ACC2) ? (sp_q + STEP1) : sp_q;
    end else begin
      mem_addr = (st_q == ST_ACC2) ? (sp_q - STEP2) : (sp_q - STEP1);
    end
    wb_en  = op_q[0] && ((st_q == ST_ACC2) || (st_q == ST_FIN));
    wb_idx = (st_q == ST_FIN && op_q[1]) ? v_q : b_q;
    wb_val = mem_rdata;
    done   = (st_q == ST_FIN);
    unique case (op_q)
      OP_PUSH:  sp_out = sp_q - STEP1;
      OP_POP:   sp_out = sp_q + STEP1;
      OP_PUSH2: sp_out = sp_q - STEP2;
      OP_POP2:  sp_out = sp_q + STEP2;
    endcase
    fault_ud = ud_q;
    fault_gp = gp_q;
  end

endmodule

// File: rtl/pair_stack_unit.sv
module pair_stack_unit
  import pstk_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ID_W       = 5,
  parameter int SP_ID      = 4,
  parameter int SLOT_BYTES = 8,
  parameter int PAIR_ALIGN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_breg,
  input  logic [ID_W-1:0]   req_vreg,
  input  logic [1:0]        req_mod,
  input  logic              req_nd,
  input  logic [DATA_W-1:0] req_sp,
  input  logic              ld_we,
  input  logic [ID_W-1:0]   ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] sp_out,
  output logic              fault_ud,
  output logic              fault_gp
);
  localparam int ALIGN_LSB = $clog2(PAIR_ALIGN);

  pstk_verdict_e     verdict;
  logic              accept;
  logic [ID_W-1:0]   rf_ridx;
  logic [DATA_W-1:0] rf_rval;
  logic              wb_en;
  logic [ID_W-1:0]   wb_idx;
  logic [DATA_W-1:0] wb_val;
  logic              rf_we;
  logic [ID_W-1:0]   rf_widx;
  logic [DATA_W-1:0] rf_wval;

  assign accept = req_valid && !busy;

  pstk_legal #(.ID_W(ID_W), .SP_ID(SP_ID), .ALIGN_LSB(ALIGN_LSB)) u_legal (
    .op      (req_op),
    .b_id    (req_breg),
    .v_id    (req_vreg),
    .mode    (req_mod),
    .nd      (req_nd),
    .sp_low  (req_sp[ALIGN_LSB-1:0]),
    .verdict (verdict)
  );

  pstk_seq #(.DATA_W(DATA_W), .ID_W(ID_W), .SLOT_BYTES(SLOT_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .verdict   (verdict),
    .req_op    (req_op),
    .req_b     (req_breg),
    .req_v     (req_vreg),
    .req_sp    (req_sp),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .rf_ridx   (rf_ridx),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_val    (wb_val),
    .done      (done),
    .sp_out    (sp_out),
    .fault_ud  (fault_ud),
    .fault_gp  (fault_gp)
  );

  // R14: pop writeback has priority over the load port
  always_comb begin
    rf_we   = wb_en || ld_we;
    rf_widx = wb_en ? wb_idx : ld_addr;
    rf_wval = wb_en ? wb_val : ld_data;
  end

  pstk_regfile #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rf (
    .clk    (clk),
    .wr_en  (rf_we),
    .wr_idx (rf_widx),
    .wr_val (rf_wval),
    .rd_idx (rf_ridx),
    .rd_val (rf_rval)
  );

  assign mem_wdata = rf_rval;

endmodule

// File: rtl/pstk_sva.sv
module pstk_sva #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [DATA_W-1:0] req_sp,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic              done,
  input logic [DATA_W-1:0] sp_out,
  input logic              fault_ud,
  input logic              fault_gp
);
  logic [1:0]        ck_op;
  logic [DATA_W-1:0] ck_sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_op <= 2'b00;
      ck_sp <= '0;
    end else if (req_valid && !busy) begin
      ck_op <= req_op;
      ck_sp <= req_sp;
    end
  end

  a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault_ud, fault_gp}));

  a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ud || fault_gp) |-> (!mem_req && !busy));

  a_r10_access_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r1_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_op == 2'b00) |-> (sp_out == ck_sp - DATA_W'(8)));

  a_r2_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_op == 2'b01) |-> (sp_out == ck_sp + DATA_W'(8)));

  a_r3_push2_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_op == 2'b10) |-> (sp_out == ck_sp - DATA_W'(16)));

  a_r4_pop2_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_op == 2'b11) |-> (sp_out == ck_sp + DATA_W'(16)));

  a_r3_second_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && ck_op == 2'b10 && mem_addr == ck_sp - DATA_W'(8))
    |=> (mem_req && mem_we && mem_addr == ck_sp - DATA_W'(16)));

  a_r9_pair_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_op[1]) |-> (ck_sp[3:0] == 4'h0));

  a_r13_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req));

endmodule

bind pair_stack_unit pstk_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_sp    (req_sp),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .done      (done),
  .sp_out    (sp_out),
  .fault_ud  (fault_ud),
  .fault_gp  (fault_gp)
);

// File: tb/test_pair_stack_unit.sv
module test_pair_stack_unit;
  localparam int CLK_PERIOD = 10;
  localparam longint WDOG   = 20000;
  localparam int KW = 0, KR = 1, KD = 2, KU = 3, KG = 4;

  typedef struct {
    int          kind;
    logic [63:0] addr;
    logic [63:0] data;
    longint      cyc;
    string       tag;
  } exp_t;

  logic        clk, rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [4:0]  req_breg, req_vreg;
  logic [1:0]  req_mod;
  logic        req_nd;
  logic [63:0] req_sp;
  logic        ld_we;
  logic [4:0]  ld_addr;
  logic [63:0] ld_data;
  logic        busy, mem_req, mem_we, done, fault_ud, fault_gp;
  logic [63:0] mem_addr, mem_wdata, mem_rdata, sp_out;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  exp_t   q[$];
  logic [63:0] ref_rf [32];
  logic [63:0] ref_mem [logic [63:0]];
  logic [63:0] sim_mem [logic [63:0]];

  pair_stack_unit i_pair_stack_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_breg(req_breg), .req_vreg(req_vreg), .req_mod(req_mod), .req_nd(req_nd),
    .req_sp(req_sp), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .sp_out(sp_out),
    .fault_ud(fault_ud), .fault_gp(fault_gp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: read data one cycle after request (R13)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we) sim_mem[mem_addr] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= sim_mem.exists(mem_addr) ? sim_mem[mem_addr] : 64'h0;
  end

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_evt(input int kind, input logic [63:0] addr, input logic [63:0] data);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: actual kind %0d addr %h expected none", kind, addr);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.addr !== addr || (kind == KW && e.data !== data) || e.cyc != cyc) begin
        errors++;
        $display("FAIL %s: actual kind %0d addr %h data %h cyc %0d expected kind %0d addr %h data %h cyc %0d",
                 e.tag, kind, addr, data, cyc, e.kind, e.addr, e.data, e.cyc);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) expect_evt(mem_we ? KW : KR, mem_addr, mem_wdata);
      if (done) expect_evt(KD, sp_out, 64'h0);
      if (fault_ud) expect_evt(KU, 64'h0, 64'h0);
      if (fault_gp) expect_evt(KG, 64'h0, 64'h0);
    end
  end

  function automatic exp_t mk(int k, logic [63:0] a, logic [63:0] d, longint c, string t);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.cyc = c; e.tag = t;
    return e;
  endfunction

  task automatic load(input int idx, input logic [63:0] val);
    ld_we = 1'b1; ld_addr = idx[4:0]; ld_data = val;
    ref_rf[idx] = val;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // driver: expectations from the requirements, then the request
  task automatic issue(input logic [1:0] op, input int b, input int v, input logic [1:0] md,
                       input logic nd, input logic [63:0] sp, input string tag);
    longint t0 = cyc;
    logic ud, gp;
    ud = op[1] && (md != 2'b11 || !nd || b == 4 || v == 4 || (op[0] && b == v));
    gp = op[1] && !ud && (sp[3:0] != 4'h0);
    if (ud) q.push_back(mk(KU, 0, 0, t0 + 1, tag));
    else if (gp) q.push_back(mk(KG, 0, 0, t0 + 1, tag));
    else begin
      case (op)
        2'b00: begin
          q.push_back(mk(KW, sp - 8, ref_rf[b], t0 + 1, tag));
          ref_mem[sp - 8] = ref_rf[b];
          q.push_back(mk(KD, sp - 8, 0, t0 + 2, tag));
        end
        2'b01: begin
          q.push_back(mk(KR, sp, 0, t0 + 1, tag));
          ref_rf[b] = ref_mem[sp];
          q.push_back(mk(KD, sp + 8, 0, t0 + 2, tag));
        end
        2'b10: begin
          q.push_back(mk(KW, sp - 8, ref_rf[b], t0 + 1, tag));
          q.push_back(mk(KW, sp - 16, ref_rf[v], t0 + 2, tag));
          ref_mem[sp - 8] = ref_rf[b];
          ref_mem[sp - 16] = ref_rf[v];
          q.push_back(mk(KD, sp - 16, 0, t0 + 3, tag));
        end
        default: begin
          q.push_back(mk(KR, sp, 0, t0 + 1, tag));
          q.push_back(mk(KR, sp + 8, 0, t0 + 2, tag));
          ref_rf[b] = ref_mem[sp];
          ref_rf[v] = ref_mem[sp + 8];
          q.push_back(mk(KD, sp + 16, 0, t0 + 3, tag));
        end
      endcase
    end
    req_valid = 1'b1; req_op = op; req_breg = b[4:0]; req_vreg = v[4:0];
    req_mod = md; req_nd = nd; req_sp = sp;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_breg = '0; req_vreg = '0;
    req_mod = 2'b11; req_nd = 1'b1; req_sp = '0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 busy", {63'h0, busy}, 64'h0);
    check("R12 mem_req", {63'h0, mem_req}, 64'h0);
    check("R12 done", {63'h0, done}, 64'h0);
    check("R12 faults", {62'h0, fault_ud, fault_gp}, 64'h0);

    // R14 load every register with a distinct value
    for (int i = 0; i < 32; i++) load(i, {32'hC0DE_0000 | 32'(i), 32'(i * 32'h0101_0101)});

    issue(2'b00, 3, 0, 2'b11, 1'b1, 64'h1000, "R1 single push");
    issue(2'b01, 4, 9, 2'b00, 1'b0, 64'h0FF8, "R11 single pop into id 4");
    issue(2'b00, 4, 4, 2'b01, 1'b0, 64'h1008, "R11 single push id 4 unaligned");
    issue(2'b10, 5, 6, 2'b11, 1'b1, 64'h2000, "R3 pair push");
    issue(2'b10, 7, 7, 2'b11, 1'b1, 64'h2100, "R8 pair push same reg legal");
    issue(2'b01, 10, 0, 2'b11, 1'b1, 64'h1FF8, "R2 single pop");
    issue(2'b00, 10, 0, 2'b11, 1'b1, 64'h3000, "R2 reveal popped reg");
    issue(2'b11, 12, 13, 2'b11, 1'b1, 64'h1FF0, "R4 pair pop");
    issue(2'b10, 12, 13, 2'b11, 1'b1, 64'h4000, "R4 reveal popped pair");

    issue(2'b10, 8, 9, 2'b10, 1'b1, 64'h2000, "R5 pair push mode 2");
    issue(2'b11, 20, 21, 2'b01, 1'b1, 64'h1FF0, "R5 R10 pair pop mode 1");
    issue(2'b11, 20, 21, 2'b11, 1'b0, 64'h1FF0, "R6 pair pop flag low");
    issue(2'b10, 4, 9, 2'b11, 1'b1, 64'h2000, "R7 pair push B is SP");
    issue(2'b11, 20, 4, 2'b11, 1'b1, 64'h1FF0, "R7 pair pop V is SP");
    issue(2'b11, 20, 20, 2'b11, 1'b1, 64'h1FF0, "R8 pair pop same reg");
    issue(2'b10, 8, 9, 2'b11, 1'b1, 64'h2008, "R9 pair push misaligned");
    issue(2'b11, 20, 21, 2'b11, 1'b1, 64'h1FF4, "R9 pair pop misaligned");
    issue(2'b10, 8, 9, 2'b00, 1'b1, 64'h2008, "R9 ud over gp");
    issue(2'b10, 20, 21, 2'b11, 1'b1, 64'h5000, "R10 regs untouched by fault");
    issue(2'b11, 22, 23, 2'b11, 1'b1, 64'h4FF0, "R13 pair pop after faults");
    issue(2'b10, 22, 23, 2'b11, 1'b1, 64'h6000, "R13 reveal");

    repeat (4) @(negedge clk);
    check("R13 all expected events seen", 64'(q.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule